// File: doc/BRIEF.md
# I2C Master Receive Word Engine

This block is the receive half of a host-paced I2C master. Once the address phase is over, it leaves SCL pulled low and waits. Each time the host reads the data register, the block releases the bus clock for one received word. It samples SDA on every SCL rising edge, most significant bit first, and shifts each bit into the low end of the data register. If acknowledge is enabled, it adds one more clock during which it pulls SDA low. When the word is done it fires a one-cycle interrupt, clears the pending flag and holds SCL low again until the next read.

The host sets the word length with a 3-bit bit-count field and turns acknowledge on or off per word. To finish a transfer, the host first clears acknowledge for the second-to-last word. It then reads one more time with bit count 1 and acknowledge off. That read produces a single clock with SDA left high, which the transmitter takes as a not-acknowledge. After the interrupt for that clock, the block issues a stop condition on its own and goes idle with both lines released.

The bus pins are open-drain and are modelled as pull-low enables plus an SDA input. SCL timing comes from a divider that gives equal high and low phases of `HALF_DIV` system clocks each.

Top module: `i2c_rx_engine`

## Requirements
- R1: After reset the block pulls SCL low, leaves SDA released, and keeps pending at 0, interrupt at 0 and the data register at 0.
- R2: A read strobe while the block is waiting with SCL held starts one word transfer, and pending reads 1 from the next cycle on.
- R3: Bit-count code 000 gives 8 data clocks and codes 001 to 111 give that many data clocks. Each data bit is sampled at SCL rise in first-to-last order and enters bit 0 of the data register while older bits move up one place.
- R4: With acknowledge enabled, one extra clock follows the data clocks with SDA pulled low. With it disabled, there is no extra clock.
- R5: At the end of a word, the interrupt is high for exactly one cycle, pending falls in that same cycle, and SCL stays pulled low until the next accepted read.
- R6: The master changes SDA only while SCL is low. The one exception is the stop condition, where SDA is released while SCL is high. SDA never changes on the edge at which SCL is released.
- R7: A read strobe that arrives during a word in progress is ignored, and the word's clock count and duration do not change.
- R8: A read with bit-count code 001 and acknowledge disabled gives exactly one clock with SDA released, so a 1 is sampled. After its interrupt, the block generates a stop: SDA is pulled low while SCL is low, SCL is released, and SDA is released at least `HALF_DIV` cycles later.
- R9: After the stop, both lines stay released, and read strobes start nothing and leave pending at 0.
- R10: A read strobe in the same cycle as the interrupt pulse is accepted and starts the next word at once.
- R11: Every SCL high phase and every low phase lasts `HALF_DIV` cycles, so a word of p clocks takes 2·`HALF_DIV`·p cycles from the accepted read to the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_cnt_i | input | 3 | Word length code, sampled at an accepted read (000 = 8 bits) |
| ack_en_i | input | 1 | Acknowledge enable, sampled at an accepted read |
| rd_stb_i | input | 1 | One-cycle strobe for a host read of the data register |
| rd_data_o | output | 8 | Data register contents |
| pend_o | output | 1 | Pending flag: 1 while a word is in progress |
| irq_o | output | 1 | One-cycle interrupt pulse at the end of each word |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sensed level of the SDA line |

## Verification
Two events can land in the same cycle: the end-of-word interrupt pulse and the host read that starts the next word. The bench provokes this by issuing every table word back to back, with each strobe driven in the very cycle in which the previous word's interrupt is seen. The test passes if pending rises and the interrupt drops in the next cycle, and if the new word then shows the expected clock count, duration and data.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  typedef enum logic [2:0] {
    ST_HOLD    = 3'd0,
    ST_LOW     = 3'd1,
    ST_HIGH    = 3'd2,
    ST_SP_PRE  = 3'd3,
    ST_SP_LOW  = 3'd4,
    ST_SP_HIGH = 3'd5,
    ST_IDLE    = 3'd6
  } rx_state_e;

endpackage

// File: rtl/rx_half_timer.sv
module rx_half_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LOAD = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == '0);

  always_comb begin
    if (!run_i || tick_o) cnt_d = LOAD;
    else                  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LOAD;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rx_shift_reg.sv
module rx_shift_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (shift_en_i) data_d = {data_q[DATA_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data_o = data_q;

endmodule

// File: rtl/rx_word_seq.sv
module rx_word_seq
  import i2c_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             rd_stb_i,
  input  logic [CNT_W-1:0] bit_cnt_i,
  input  logic             ack_en_i,
  output logic             run_o,
  output logic             shift_en_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             pend_o,
  output logic             irq_o,
  output logic             hold_o,
  output logic             idle_o
);

  localparam int PW = CNT_W + 1;

  rx_state_e      state_q, state_d;
  logic [PW-1:0]  left_q, left_d;
  logic           ack_q, ack_d;
  logic           term_q, term_d;
  logic           pend_q, pend_d;
  logic           irq_q, irq_d;
  logic           sda_q, sda_d;
  logic [PW-1:0]  nbits_w;
  logic           ack_bit_w;

  assign nbits_w   = (bit_cnt_i == '0) ? PW'(DATA_W) : {1'b0, bit_cnt_i};
  assign ack_bit_w = ack_q && (left_q == PW'(1));

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    ack_d   = ack_q;
    term_d  = term_q;
    pend_d  = pend_q;
    irq_d   = 1'b0;
    unique case (state_q)
      ST_HOLD: begin
        if (rd_stb_i) begin
          state_d = ST_LOW;
          left_d  = nbits_w + {{CNT_W{1'b0}}, ack_en_i};
          ack_d   = ack_en_i;
          term_d  = (bit_cnt_i == CNT_W'(1)) && !ack_en_i;
          pend_d  = 1'b1;
        end
      end
      ST_LOW: if (tick_i) state_d = ST_HIGH;
      ST_HIGH: begin
        if (tick_i) begin
          if (left_q == PW'(1)) begin
            pend_d  = 1'b0;
            irq_d   = 1'b1;
            state_d = term_q ? ST_SP_PRE : ST_HOLD;
          end else begin
            left_d  = left_q - PW'(1);
            state_d = ST_LOW;
          end
        end
      end
      ST_SP_PRE:  if (tick_i) state_d = ST_SP_LOW;
      ST_SP_LOW:  if (tick_i) state_d = ST_SP_HIGH;
      ST_SP_HIGH: if (tick_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // SDA enable is registered one cycle behind the state so that it never
  // moves on the same edge as SCL.
  always_comb begin
    sda_d = 1'b0;
    if ((state_q == ST_LOW || state_q == ST_HIGH) && ack_bit_w) sda_d = 1'b1;
    if (state_q == ST_SP_LOW || state_q == ST_SP_HIGH)          sda_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      left_q  <= '0;
      ack_q   <= 1'b0;
      term_q  <= 1'b0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      ack_q   <= ack_d;
      term_q  <= term_d;
      pend_q  <= pend_d;
      irq_q   <= irq_d;
      sda_q   <= sda_d;
    end
  end

  assign run_o      = (state_q != ST_HOLD) && (state_q != ST_IDLE);
  assign shift_en_o = (state_q == ST_LOW) && tick_i && !ack_bit_w;
  assign scl_oe_o   = (state_q == ST_HOLD) || (state_q == ST_LOW) ||
                      (state_q == ST_SP_PRE) || (state_q == ST_SP_LOW);
  assign sda_oe_o   = sda_q;
  assign pend_o     = pend_q;
  assign irq_o      = irq_q;
  assign hold_o     = (state_q == ST_HOLD);
  assign idle_o     = (state_q == ST_IDLE);

endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine #(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic              ack_en_i,
  input  logic              rd_stb_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pend_o,
  output logic              irq_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic rst_s_n;
  logic tick_w, run_w, shift_w, hold_w, idle_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[SYNC_STAGES-1];

  rx_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .run_i  (run_w),
    .tick_o (tick_w)
  );

  rx_shift_reg #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .shift_en_i (shift_w),
    .bit_i      (sda_i),
    .data_o     (rd_data_o)
  );

  rx_word_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .tick_i     (tick_w),
    .rd_stb_i   (rd_stb_i),
    .bit_cnt_i  (bit_cnt_i),
    .ack_en_i   (ack_en_i),
    .run_o      (run_w),
    .shift_en_o (shift_w),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .pend_o     (pend_o),
    .irq_o      (irq_o),
    .hold_o     (hold_w),
    .idle_o     (idle_w)
  );

endmodule

// File: rtl/i2c_rx_engine_chk.sv
module i2c_rx_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_stb_i,
  input logic pend_o,
  input logic irq_o,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic hold_i,
  input logic idle_i
);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && rd_stb_i) |=> pend_o);

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> irq_o);

  p_irq_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> scl_oe_o);

  p_sda_while_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe_o && !$past(scl_oe_o) && !$stable(sda_oe_o)) |-> $fell(sda_oe_o));

  p_sda_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe_o && $past(scl_oe_o)) |-> $stable(sda_oe_o));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && rd_stb_i) |=> (!pend_o && !scl_oe_o));

endmodule

bind i2c_rx_engine i2c_rx_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .rd_stb_i (rd_stb_i),
  .pend_o   (pend_o),
  .irq_o    (irq_o),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o),
  .hold_i   (hold_w),
  .idle_i   (idle_w)
);

// File: tb/test_i2c_rx_engine.sv
module test_i2c_rx_engine;

  localparam int H = 4;
  localparam int NV = 6;
  // entry: [11:9] bit-count code, [8] ack enable, [7:0] slave byte
  localparam logic [11:0] VEC [NV] = '{
    {3'b000, 1'b1, 8'hA5},
    {3'b000, 1'b1, 8'h3C},
    {3'b011, 1'b1, 8'hE0},
    {3'b111, 1'b1, 8'h5A},
    {3'b101, 1'b0, 8'h9B},
    {3'b000, 1'b0, 8'hC3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bit_cnt = 3'b000;
  logic ack_en = 1'b0;
  logic rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic pend, irq, scl_oe, sda_oe;
  logic slave_sda = 1'b1;
  wire  scl_line = !scl_oe;
  wire  sda_line = !sda_oe && slave_sda;

  int total = 0, bad = 0;
  int rises = 0, stops = 0, bad_edges = 0;
  int idx = 0, slave_n = 0;
  logic [7:0] slave_byte = 8'h00;
  logic last_sda = 1'b0;
  logic [7:0] exp_data = 8'h00;
  longint cyc = 0, scl_rise_cyc = 0, stop_cyc = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  i2c_rx_engine #(.HALF_DIV(H)) i_i2c_rx_engine (
    .clk(clk), .rst_n(rst_n), .bit_cnt_i(bit_cnt), .ack_en_i(ack_en),
    .rd_stb_i(rd_stb), .rd_data_o(rd_data), .pend_o(pend), .irq_o(irq),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge scl_line) begin
    rises++;
    last_sda = sda_line;
    scl_rise_cyc = cyc;
  end

  always @(negedge scl_line) begin
    idx++;
    slave_sda = (idx < slave_n) ? slave_byte[7-idx] : 1'b1;
  end

  always @(sda_line) begin
    if (scl_line === 1'b1) begin
      if (sda_line === 1'b1) begin
        stops++;
        stop_cyc = cyc;
      end else bad_edges++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling clock edge; leaves the bench at the negedge where irq is seen
  task automatic run_word(input logic [2:0] code, input logic ack, input logic [7:0] byt,
                          input int sn, input bit mid);
    int nb, p, n, r0;
    nb = (code == 3'b000) ? 8 : int'(code);
    p  = nb + int'(ack);
    slave_byte = byt;
    slave_n = sn;
    idx = 0;
    slave_sda = (sn > 0) ? byt[7] : 1'b1;
    r0 = rises;
    bit_cnt = code;
    ack_en = ack;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    n = 1;
    chk(pend == 1'b1, "R2 pending after read", pend, 1);
    chk(irq == 1'b0, "R10 irq dropped as next word starts", irq, 0);
    while (!irq && n < 5000) begin
      @(negedge clk);
      n++;
      rd_stb = mid && (n == 3); // R7: strobe mid-word
    end
    rd_stb = 1'b0;
    chk(n == 2*H*p + 1, "R11 word duration", n, 2*H*p + 1);
    chk(rises - r0 == p, "R3/R4 clock count", rises - r0, p);
    chk(pend == 1'b0, "R5 pending cleared", pend, 0);
    chk(scl_oe == 1'b1, "R5 SCL held low", scl_oe, 1);
    if (ack) chk(last_sda == 1'b0, "R4 acknowledge low", last_sda, 0);
    for (int i = 0; i < nb; i++)
      exp_data = {exp_data[6:0], (i < sn) ? byt[7-i] : 1'b1};
    chk(rd_data == exp_data, "R3 data register", rd_data, exp_data);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scl_oe == 1'b1, "R1 SCL low", scl_oe, 1);
    chk(sda_oe == 1'b0, "R1 SDA released", sda_oe, 0);
    chk(pend == 1'b0, "R1 pending", pend, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(rd_data == 8'h00, "R1 data", rd_data, 0);

    // table words issued back to back (R10)
    for (int v = 0; v < NV; v++)
      run_word(VEC[v][11:9], VEC[v][8], VEC[v][7:0], (VEC[v][11:9] == 3'b000) ? 8 : int'(VEC[v][11:9]), v == 1);

    // R5: irq single cycle, SCL held while no read
    r1 = rises;
    @(negedge clk);
    chk(irq == 1'b0, "R5 irq one cycle", irq, 0);
    repeat (20) @(negedge clk);
    chk(scl_oe == 1'b1 && rises == r1, "R5 SCL held until read", rises - r1, 0);

    // R8: terminating single released clock, then stop
    run_word(3'b001, 1'b0, 8'h00, 0, 1'b0);
    chk(last_sda == 1'b1, "R8 released clock reads high", last_sda, 1);
    r1 = rises;
    for (int k = 0; k < 200 && stops == 0; k++) @(negedge clk);
    chk(stops == 1, "R8 stop seen", stops, 1);
    chk(rises - r1 == 1, "R8 one SCL release for stop", rises - r1, 1);
    chk(stop_cyc - scl_rise_cyc >= H, "R8 stop setup", stop_cyc - scl_rise_cyc, H);
    repeat (3) @(negedge clk);
    chk(scl_line == 1'b1 && sda_line == 1'b1, "R9 lines released", {scl_line, sda_line}, 3);

    // R9: strobe after stop does nothing
    r1 = rises;
    bit_cnt = 3'b000;
    ack_en = 1'b1;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    repeat (4*H*9) @(negedge clk);
    chk(pend == 1'b0, "R9 pending stays 0", pend, 0);
    chk(rises == r1 && scl_line == 1'b1, "R9 no clocks after stop", rises - r1, 0);
    chk(bad_edges == 0, "R6 SDA moved while SCL high", bad_edges, 0);
    chk(stops == 1, "R6 single stop edge", stops, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule